// File: doc/BRIEF.md
# Program memory partition access guard

This block decides, for every access to a 17-bit program memory, whether that access may go ahead. A one-time-programmable limit register sets a boundary that splits the memory into two regions. The protected lower region runs from address zero up to the boundary and excludes the boundary itself. The open upper region runs from the boundary to the top of memory. The block compares the region of the requesting instruction (its program counter) with the region of the target address. Code that runs from the upper region may still fetch and execute lower-region instructions. It may not read them as data, and it may not write or erase them.

The core issues a data-style code read (a table lookup) together with the byte that the memory array returned. On a granted read the block passes that byte through. On a denied read it substitutes a fixed filler byte. A denied write or erase loses its grant, so the memory controller drops it. Every denied request raises a violation pulse on the following cycle. The limit register takes its first write after reset and ignores all later writes until the next reset. A status bit shows when the limit is locked.

Top module: `code_partition_guard`

## Requirements
- R1: After synchronous reset the limit register reads 0x00, the locked bit is 0 and violation is 0. The boundary is therefore at 0x00000 and every read, write and erase is granted.
- R2: The boundary address is the 8-bit limit value placed in bits 16..9, with bits 8..0 at zero. An address below the boundary is in the lower region. An address equal to or above the boundary is in the upper region.
- R3: Only the first limit write after reset takes effect. It also sets the locked bit. Any later write leaves the limit value unchanged until the next reset.
- R4: A read whose pc is in the upper region and whose target is in the lower region is denied. rd_grant is 0 and rd_data is 0xFF.
- R5: A granted read drives rd_grant to 1 and passes rd_mem_data unchanged to rd_data.
- R6: When pc is in the lower region, reads, writes and erases to any address are granted.
- R7: A write or erase (pgm_erase=1 for erase, 0 for write) is denied when pc is in the upper region and the target is in the lower region. It is granted when the target is in the upper region.
- R8: An instruction fetch is always granted, whatever the limit and the pc.
- R9: violation is 1 in the cycle after a clock edge at which a read or a write/erase was denied. It is 0 in the cycle after an edge at which nothing was denied.
- R10: With an odd limit value, an erase aimed at an upper-region address is granted even when that address lies in the same 1024-byte sector as protected addresses. This is the partial exposure that an odd limit causes.
- R11: A limit write changes the decisions from the cycle after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Limit register write strobe |
| cfg_wr_data | input | 8 | Limit value to write |
| cfg_rd_data | output | 8 | Current limit value |
| cfg_locked | output | 1 | Limit already written since reset |
| pc | input | 17 | Address of the issuing instruction |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_grant | output | 1 | Fetch allowed |
| rd_req | input | 1 | Data-style code read request |
| rd_addr | input | 17 | Read target address |
| rd_mem_data | input | 8 | Byte returned by the memory array |
| rd_grant | output | 1 | Read allowed |
| rd_data | output | 8 | Read result or 0xFF filler |
| pgm_req | input | 1 | Write or erase request |
| pgm_erase | input | 1 | 1 = erase, 0 = write |
| pgm_addr | input | 17 | Write/erase target address |
| pgm_grant | output | 1 | Write/erase allowed |
| violation | output | 1 | Registered pulse after a denied request |

## Verification
The only internal state is the limit value and its lock bit, and a fault in either shows up one clock after the write that was meant to set it. A lost lock lets a second write move the boundary, so cfg_rd_data changes and reads near the old boundary flip between grant and deny. An off-by-one error in the region compare shows only at exactly boundary-1 and at the boundary itself, so the bench probes both addresses. A wrong violation register shows in the single cycle after a denied request.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef struct packed {
    logic grant;
    logic deny;
  } cpg_verdict_t;
endpackage

// File: rtl/cpg_limit_reg.sv
module cpg_limit_reg #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LIM_W-1:0] wr_data,
  output logic [LIM_W-1:0] limit,
  output logic             locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      limit  <= '0;
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      limit  <= wr_data;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/cpg_region_cmp.sv
module cpg_region_cmp #(
  parameter int ADDR_W = 17,
  parameter int LIM_W  = 8
) (
  input  logic [LIM_W-1:0]  limit,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_low
);
  localparam int LOW_W = ADDR_W - LIM_W;
  logic [ADDR_W-1:0] boundary;
  always_comb begin
    boundary = {limit, {LOW_W{1'b0}}};
    is_low   = (addr < boundary);
  end
endmodule

// File: rtl/cpg_gate.sv
module cpg_gate
  import cpg_pkg::*;
(
  input  logic         req,
  input  logic         src_low,
  input  logic         tgt_low,
  output cpg_verdict_t verdict
);
  logic blocked;
  always_comb begin
    blocked       = !src_low && tgt_low;
    verdict.grant = req && !blocked;
    verdict.deny  = req && blocked;
  end
endmodule

// File: rtl/code_partition_guard.sv
module code_partition_guard
  import cpg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LIM_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [LIM_W-1:0]  cfg_wr_data,
  output logic [LIM_W-1:0]  cfg_rd_data,
  output logic              cfg_locked,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fetch_req,
  output logic              fetch_grant,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_mem_data,
  output logic              rd_grant,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pgm_req,
  input  logic              pgm_erase,
  input  logic [ADDR_W-1:0] pgm_addr,
  output logic              pgm_grant,
  output logic              violation
);
  localparam int NCMP = 3;  // 0: pc, 1: read target, 2: write/erase target

  logic [LIM_W-1:0] limit;
  logic [NCMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [NCMP-1:0] cmp_low;
  cpg_verdict_t rd_v, pgm_v;
  logic viol_q;

  cpg_limit_reg #(.LIM_W(LIM_W)) u_limit (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .limit(limit), .locked(cfg_locked)
  );

  assign cmp_addr[0] = pc;
  assign cmp_addr[1] = rd_addr;
  assign cmp_addr[2] = pgm_addr;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    cpg_region_cmp #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_cmp (
      .limit(limit), .addr(cmp_addr[g]), .is_low(cmp_low[g])
    );
  end

  cpg_gate u_rd_gate (
    .req(rd_req), .src_low(cmp_low[0]), .tgt_low(cmp_low[1]), .verdict(rd_v)
  );

  // Write and erase share one gate; the erase flag only selects the array operation downstream.
  logic pgm_kind_unused;
  assign pgm_kind_unused = pgm_erase;

  cpg_gate u_pgm_gate (
    .req(pgm_req), .src_low(cmp_low[0]), .tgt_low(cmp_low[2]), .verdict(pgm_v)
  );

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else     viol_q <= rd_v.deny || pgm_v.deny;
  end

  always_comb begin
    cfg_rd_data = limit;
    fetch_grant = fetch_req;
    rd_grant    = rd_v.grant;
    rd_data     = rd_v.deny ? FILL : rd_mem_data;
    pgm_grant   = pgm_v.grant;
    violation   = viol_q;
  end
endmodule

// File: rtl/code_partition_guard_chk.sv
module code_partition_guard_chk #(
  parameter int ADDR_W = 17,
  parameter int LIM_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic [LIM_W-1:0]  cfg_rd_data,
  input logic              cfg_locked,
  input logic [ADDR_W-1:0] pc,
  input logic              fetch_req,
  input logic              fetch_grant,
  input logic              rd_req,
  input logic              rd_grant,
  input logic [DATA_W-1:0] rd_data,
  input logic              pgm_req,
  input logic              pgm_grant,
  input logic              violation
);
  localparam int LOW_W = ADDR_W - LIM_W;
  logic pc_low;
  assign pc_low = pc < {cfg_rd_data, {LOW_W{1'b0}}};

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> cfg_locked);
  // R3
  limit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> $stable(cfg_rd_data));
  // R3
  first_write_locks_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en |=> cfg_locked);
  // R4
  deny_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_grant) |-> (rd_data == '1));
  // R6
  low_src_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && pc_low) |-> rd_grant);
  // R6
  low_src_pgm_chk: assert property (@(posedge clk) disable iff (rst)
    (pgm_req && pc_low) |-> pgm_grant);
  // R8
  fetch_open_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> fetch_grant);
  // R9
  viol_after_deny_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_req && !rd_grant) || (pgm_req && !pgm_grant)) |=> violation);
endmodule

bind code_partition_guard code_partition_guard_chk #(
  .ADDR_W(ADDR_W), .LIM_W(LIM_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .cfg_locked(cfg_locked), .pc(pc), .fetch_req(fetch_req),
  .fetch_grant(fetch_grant), .rd_req(rd_req), .rd_grant(rd_grant),
  .rd_data(rd_data), .pgm_req(pgm_req), .pgm_grant(pgm_grant),
  .violation(violation)
);

// File: tb/test_code_partition_guard.sv
module test_code_partition_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic        cfg_locked;
  logic [16:0] pc;
  logic        fetch_req;
  logic        fetch_grant;
  logic        rd_req;
  logic [16:0] rd_addr;
  logic [7:0]  rd_mem_data;
  logic        rd_grant;
  logic [7:0]  rd_data;
  logic        pgm_req;
  logic        pgm_erase;
  logic [16:0] pgm_addr;
  logic        pgm_grant;
  logic        violation;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  code_partition_guard i_code_partition_guard (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_wr_en = 0; cfg_wr_data = 0; fetch_req = 0; rd_req = 0; rd_addr = 0;
    rd_mem_data = 8'h5A; pgm_req = 0; pgm_erase = 0; pgm_addr = 0; pc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic write_limit(logic [7:0] v);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 limit", cfg_rd_data, 0);
    check("R1 locked", cfg_locked, 0);
    check("R1 violation", violation, 0);
    pc = 17'h1FFFF; rd_req = 1; rd_addr = 0; rd_mem_data = 8'h3C; #1;
    check("R1 read granted", rd_grant, 1);
    check("R5 data passed", rd_data, 8'h3C);
    pgm_req = 1; pgm_addr = 0; #1;
    check("R1 write granted", pgm_grant, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_lock();
    write_limit(8'h10);
    check("R11 limit stored", cfg_rd_data, 8'h10);
    check("R3 locked", cfg_locked, 1);
    write_limit(8'h40);
    check("R3 second write ignored", cfg_rd_data, 8'h10);
    pc = 17'h03000; rd_req = 1; rd_addr = 17'h02800; #1;
    check("R3 old boundary kept", rd_grant, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_boundary();
    pc = 17'h02000; rd_req = 1; rd_addr = 17'h01FFF; rd_mem_data = 8'h77; #1;
    check("R4 grant at limit-1", rd_grant, 0);
    check("R4 fill byte", rd_data, 8'hFF);
    check("R2 pc at limit is upper", rd_grant, 0);
    @(negedge clk);
    check("R9 violation after deny", violation, 1);
    rd_addr = 17'h02000; #1;
    check("R2 target at limit is upper", rd_grant, 1);
    check("R5 data passed", rd_data, 8'h77);
    @(negedge clk);
    check("R9 violation clears", violation, 0);
    idle();
  endtask

  task automatic t_lower();
    pc = 17'h01FFF; rd_req = 1; rd_addr = 17'h00000; #1;
    check("R6 low read", rd_grant, 1);
    pgm_req = 1; pgm_erase = 0; pgm_addr = 17'h00100; #1;
    check("R6 low write", pgm_grant, 1);
    pgm_erase = 1; pgm_addr = 17'h1F000; #1;
    check("R6 low erase upper", pgm_grant, 1);
    @(negedge clk);
    check("R9 no violation", violation, 0);
    idle();
  endtask

  task automatic t_upper_pgm();
    pc = 17'h03000; pgm_req = 1; pgm_erase = 0; pgm_addr = 17'h01000; #1;
    check("R7 upper write lower", pgm_grant, 0);
    @(negedge clk);
    check("R9 violation on write deny", violation, 1);
    pgm_erase = 1; pgm_addr = 17'h01FFF; #1;
    check("R7 upper erase lower", pgm_grant, 0);
    pgm_erase = 0; pgm_addr = 17'h02000; #1;
    check("R7 upper write upper", pgm_grant, 1);
    @(negedge clk);
    check("R9 clears after grant", violation, 0);
    idle();
  endtask

  task automatic t_fetch();
    pc = 17'h1F000; fetch_req = 1; #1;
    check("R8 fetch granted", fetch_grant, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_odd();
    do_reset();
    check("R1 limit after reset", cfg_rd_data, 0);
    pc = 17'h08000; rd_req = 1; rd_addr = 17'h00500; #1;
    check("R11 before write", rd_grant, 1);
    rd_req = 0;
    write_limit(8'h03);
    pc = 17'h08000; rd_req = 1; rd_addr = 17'h00500; #1;
    check("R11 after write", rd_grant, 0);
    rd_req = 0; pgm_req = 1; pgm_erase = 1; pgm_addr = 17'h00600; #1;
    check("R10 erase in shared sector", pgm_grant, 1);
    pgm_addr = 17'h005FF; #1;
    check("R7 erase below odd limit", pgm_grant, 0);
    @(negedge clk); idle();
  endtask

  initial begin
    #500000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(); rst = 1;
    t_reset();
    t_lock();
    t_boundary();
    t_lower();
    t_upper_pgm();
    t_fetch();
    t_odd();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule